// File: doc/BRIEF.md
# Counter Array Control and Flag Register

This block is the 8-bit control and status register beside a free-running counter that serves five compare/capture modules. It stores a run bit that enables the counter, an overflow flag, and one sticky event flag for each module. Hardware sets the flags on counter rollover and on module match or capture pulses. Only software clears them, by writing the register.

Software writes the register through a simple port made of an address, a write enable and a data byte. The full register value is always present on the read output. The block drives the counter's run enable. It also raises one interrupt request, formed from the overflow flag (gated by an external enable bit) and from every module flag.

Bit positions: bit 7 is the overflow flag, bit 6 is run, bit 5 is a reserved storage bit, and bits 4..0 are the event flags of modules 4..0.

Top module: `cntarr_ctrl_reg`

## Requirements
- R1: After reset the read value is 8'h00, `run_o` is 0 and `irq_o` is 0.
- R2: The register state is unchanged when `we_i` is low, or when `addr_i` differs from `REG_ADDR` (default 8'hD8), provided no hardware event arrives.
- R3: A pulse on `evt_i[n]` sets bit n of the read value at the next clock edge. The bit stays set until software clears it.
- R4: A write of 0 to bit n (n in 0..4) clears module flag n. A write of 1 to that bit leaves the flag unchanged.
- R5: When `evt_i[n]` arrives in the same cycle as a write that clears flag n, the flag ends up set.
- R6: A pulse on `rollover_i` sets bit 7. A write sets bit 7 when the data bit is 1 and clears it when the data bit is 0.
- R7: When `rollover_i` arrives in the same cycle as a write of 0 to bit 7, bit 7 ends up set.
- R8: Bit 6 takes the written value and drives `run_o`. It changes only on a register write, and hardware events leave it unchanged.
- R9: Bit 5 stores the written value and reads it back. It has no effect on `run_o` or `irq_o`.
- R10: `irq_o` is 1 when (bit 7 AND `ovf_ie_i`) is 1, or when any of bits 4..0 is 1. It follows `ovf_ie_i` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Register write address |
| we_i | input | 1 | Write enable |
| wdata_i | input | 8 | Write data |
| rollover_i | input | 1 | Counter rollover pulse |
| evt_i | input | NUM_MOD | Module match/capture pulses |
| ovf_ie_i | input | 1 | Overflow interrupt enable |
| rdata_o | output | 8 | Current register value |
| run_o | output | 1 | Counter run enable |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Every stored bit reaches `rdata_o` directly, one edge after the event or write that changes it. A flag that is lost, that sets itself, or that ignores a priority rule is therefore visible at the next sample. A wrong run bit shows on `run_o` in the same cycle it shows in the read value. A wrong gating or OR term shows on `irq_o` without delay, so the bench toggles `ovf_ie_i` and checks the response within the same cycle. The race cases are driven on a single edge, and the bench reads the result on the following sample.

// File: rtl/cntarr_pkg.sv
package cntarr_pkg;
  localparam int unsigned REG_W   = 8;
  localparam int unsigned OVF_BIT = 7;
  localparam int unsigned RUN_BIT = 6;
  localparam int unsigned RSV_BIT = 5;
  localparam int unsigned MOD_MAX = 5;
endpackage

// File: rtl/cntarr_sticky_bit.sv
module cntarr_sticky_bit #(
  parameter bit SW_SET = 1'b0  // 1: software may also set the flag
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hw_set_i,
  input  logic sw_we_i,
  input  logic sw_d_i,
  output logic q_o
);
  generate
    if (SW_SET) begin : g_sw_rw
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       q_o <= 1'b0;
        else if (hw_set_i) q_o <= 1'b1;
        else if (sw_we_i)  q_o <= sw_d_i;
      end
    end else begin : g_sw_clr
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                  q_o <= 1'b0;
        else if (hw_set_i)            q_o <= 1'b1;
        else if (sw_we_i && !sw_d_i)  q_o <= 1'b0;
      end
    end
  endgenerate

  // R3 R5 R7
  hw_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_set_i |=> q_o);

  // R4
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_o && !(sw_we_i && !sw_d_i)) |=> q_o);
endmodule

// File: rtl/cntarr_store_bit.sv
module cntarr_store_bit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic we_i,
  input  logic d_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= 1'b0;
    else if (we_i) q_o <= d_i;
  end
endmodule

// File: rtl/cntarr_irq_merge.sv
module cntarr_irq_merge #(
  parameter int unsigned NUM_MOD = 5
) (
  input  logic               ovf_i,
  input  logic               ovf_ie_i,
  input  logic [NUM_MOD-1:0] mod_i,
  output logic               irq_o
);
  always_comb irq_o = (ovf_i & ovf_ie_i) | (|mod_i);
endmodule

// File: rtl/cntarr_ctrl_reg.sv
module cntarr_ctrl_reg
  import cntarr_pkg::*;
#(
  parameter int unsigned NUM_MOD  = 5,
  parameter logic [7:0]  REG_ADDR = 8'hD8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [7:0]         addr_i,
  input  logic               we_i,
  input  logic [REG_W-1:0]   wdata_i,
  input  logic               rollover_i,
  input  logic [NUM_MOD-1:0] evt_i,
  input  logic               ovf_ie_i,
  output logic [REG_W-1:0]   rdata_o,
  output logic               run_o,
  output logic               irq_o
);
  logic               wr_sel;
  logic               ovf_q;
  logic               run_q;
  logic               rsv_q;
  logic [NUM_MOD-1:0] mod_q;

  assign wr_sel = we_i && (addr_i == REG_ADDR);

  for (genvar n = 0; n < NUM_MOD; n++) begin : g_mod
    cntarr_sticky_bit #(.SW_SET(1'b0)) i_flag (
      .clk_i, .rst_ni,
      .hw_set_i (evt_i[n]),
      .sw_we_i  (wr_sel),
      .sw_d_i   (wdata_i[n]),
      .q_o      (mod_q[n])
    );
  end

  cntarr_sticky_bit #(.SW_SET(1'b1)) i_ovf (
    .clk_i, .rst_ni,
    .hw_set_i (rollover_i),
    .sw_we_i  (wr_sel),
    .sw_d_i   (wdata_i[OVF_BIT]),
    .q_o      (ovf_q)
  );

  cntarr_store_bit i_run (
    .clk_i, .rst_ni, .we_i(wr_sel), .d_i(wdata_i[RUN_BIT]), .q_o(run_q)
  );

  cntarr_store_bit i_rsv (
    .clk_i, .rst_ni, .we_i(wr_sel), .d_i(wdata_i[RSV_BIT]), .q_o(rsv_q)
  );

  cntarr_irq_merge #(.NUM_MOD(NUM_MOD)) i_irq (
    .ovf_i(ovf_q), .ovf_ie_i, .mod_i(mod_q), .irq_o
  );

  always_comb begin
    rdata_o                = '0;
    rdata_o[NUM_MOD-1:0]   = mod_q;
    rdata_o[RSV_BIT]       = rsv_q;
    rdata_o[RUN_BIT]       = run_q;
    rdata_o[OVF_BIT]       = ovf_q;
  end

  assign run_o = run_q;

  initial begin
    num_mod_chk: assert (NUM_MOD >= 1 && NUM_MOD <= MOD_MAX);
  end

  // R8
  run_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_sel |=> $stable(run_o));

  // R2
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_sel && !rollover_i && !(|evt_i)) |=> $stable(rdata_o));

  // R10
  irq_mod_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|mod_q) |-> irq_o);

  // R10
  irq_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ovf_q && !(|mod_q)) |-> !irq_o);
endmodule

// File: tb/test_cntarr_ctrl_reg.sv
module test_cntarr_ctrl_reg;
  localparam int CLK_PERIOD = 10;
  localparam int NM = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] addr = 8'h00;
  logic       we = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic       roll = 1'b0;
  logic [NM-1:0] evt = '0;
  logic       ie = 1'b0;
  logic [7:0] rdata;
  logic       run, irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cntarr_ctrl_reg #(.NUM_MOD(NM), .REG_ADDR(8'hD8)) i_cntarr_ctrl_reg (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rollover_i(roll), .evt_i(evt), .ovf_ie_i(ie),
    .rdata_o(rdata), .run_o(run), .irq_o(irq)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one cycle of stimulus, then sample at the next falling edge
  task automatic step(logic w, logic [7:0] a, logic [7:0] d, logic r, logic [NM-1:0] e);
    @(negedge clk);
    we = w; addr = a; wdata = d; roll = r; evt = e;
    @(negedge clk);
    we = 1'b0; roll = 1'b0; evt = '0;
  endtask

  task automatic t_reset;
    chk("R1 rdata", rdata, 8'h00);
    chk("R1 run", {7'd0, run}, 8'd0);
    chk("R1 irq", {7'd0, irq}, 8'd0);
  endtask

  task automatic t_events;
    step(1'b0, 8'h00, 8'h00, 1'b0, 5'b00101);
    chk("R3 set", rdata, 8'h05);
    chk("R10 mod irq", {7'd0, irq}, 8'd1);
    repeat (3) @(negedge clk);
    chk("R3 sticky", rdata, 8'h05);
  endtask

  task automatic t_sw_clear;
    step(1'b1, 8'hD8, 8'h04, 1'b0, '0);
    chk("R4 w1 keeps w0 clears", rdata, 8'h04);
    step(1'b1, 8'hD8, 8'h00, 1'b0, '0);
    chk("R4 clear", rdata, 8'h00);
    chk("R10 no irq", {7'd0, irq}, 8'd0);
  endtask

  task automatic t_ignored;
    step(1'b0, 8'h00, 8'h00, 1'b0, 5'b10000);
    step(1'b1, 8'hD9, 8'h40, 1'b0, '0);
    chk("R2 other addr", rdata, 8'h10);
    step(1'b0, 8'hD8, 8'h40, 1'b0, '0);
    chk("R2 we low", rdata, 8'h10);
    chk("R2 run", {7'd0, run}, 8'd0);
    step(1'b1, 8'hD8, 8'h00, 1'b0, '0);
  endtask

  task automatic t_race;
    step(1'b1, 8'hD8, 8'h00, 1'b0, 5'b01000);
    chk("R5 set wins", rdata, 8'h08);
    step(1'b1, 8'hD8, 8'h00, 1'b0, '0);
    chk("R5 cleanup", rdata, 8'h00);
  endtask

  task automatic t_ovf;
    step(1'b0, 8'h00, 8'h00, 1'b1, '0);
    chk("R6 rollover", rdata, 8'h80);
    ie = 1'b0; #1;
    chk("R10 gated", {7'd0, irq}, 8'd0);
    ie = 1'b1; #1;
    chk("R10 enabled", {7'd0, irq}, 8'd1);
    step(1'b1, 8'hD8, 8'h00, 1'b0, '0);
    chk("R6 sw clear", rdata, 8'h00);
    step(1'b1, 8'hD8, 8'h80, 1'b0, '0);
    chk("R6 sw set", rdata, 8'h80);
    step(1'b1, 8'hD8, 8'h00, 1'b0, '0);
    step(1'b1, 8'hD8, 8'h00, 1'b1, '0);
    chk("R7 rollover wins", rdata, 8'h80);
    step(1'b1, 8'hD8, 8'h00, 1'b0, '0);
    ie = 1'b0;
  endtask

  task automatic t_run;
    step(1'b1, 8'hD8, 8'h40, 1'b0, '0);
    chk("R8 run on", {7'd0, run}, 8'd1);
    chk("R8 rdata", rdata, 8'h40);
    step(1'b0, 8'h00, 8'h00, 1'b1, 5'b11111);
    chk("R8 hw keeps run", rdata, 8'hDF);
    step(1'b1, 8'hD8, 8'h00, 1'b0, '0);
    chk("R8 run off", {7'd0, run}, 8'd0);
    chk("R8 all cleared", rdata, 8'h00);
  endtask

  task automatic t_reserved;
    step(1'b1, 8'hD8, 8'h20, 1'b0, '0);
    chk("R9 readback", rdata, 8'h20);
    chk("R9 no run", {7'd0, run}, 8'd0);
    ie = 1'b1; #1;
    chk("R9 no irq", {7'd0, irq}, 8'd0);
    ie = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_events();
    t_sw_clear();
    t_ignored();
    t_race();
    t_ovf();
    t_run();
    t_reserved();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule